// File: doc/BRIEF.md
# Synchronous Serial Port Status and Interrupt Register

This block holds the status word of a synchronous serial port and drives its interrupt requests. The serial engine reports two kinds of fault as single-cycle pulses: a frame-sync pulse that arrives at the wrong time (a bit-count error) and an attempt to pop an empty transmit FIFO (an underrun). Each fault is held in a sticky bit. The bit stays set until the CPU writes a one to its position, or until the port is disabled. FIFO levels, the busy indication and the clock-synchronisation busy indication are passed straight through as read-only flags.

The CPU reads a 32-bit status word combinationally and writes to it with a one-cycle write strobe. A small resynchronisation helper sits in the receive sample path. After a bit-count error it discards the sample that is in flight and the one after it, so that the port can realign with the frame master.

Top module: `sspstat_reg`

## Requirements
- R1: Bit 23 (bit-count error) is set by a `bce_evt` pulse while `port_en` is 1. It is cleared only by a write with `wr_data[23]`=1. A write with `wr_data[23]`=0 leaves it unchanged.
- R2: If a set event and a write-one-to-clear reach the same sticky bit in the same cycle, the bit ends up set.
- R3: `irq_bce` is 1 exactly while bit 23 is 1 and `bce_ie` is 1.
- R4: A `bce_evt` pulse while enabled causes the next two valid receive samples to be dropped (`rx_sample_keep`=0). A sample that is valid in the same cycle as the pulse counts as the first of the two.
- R5: Bit 21 (transmit underrun) is set by `tx_pop_empty` only when `frm_slave`=1 and `rx_no_tx`=0. Otherwise the pulse is ignored. The bit is cleared by writing 1 to bit 21.
- R6: Bit 22 reads `css_busy` while `frm_slave`=1 and reads 0 otherwise. Writes do not affect it.
- R7: The read-only flags follow their inputs in the same cycle, and writes are ignored. The layout is: `tx_nf` at bit 2, `rx_ne` at bit 3, `busy` at bit 4, `tx_level` at bits [11:8], `rx_level` at bits [15:12].
- R8: Bits [31:24], [20:16] and [7:5], [1:0] read as 0 whatever is written.
- R9: `irq_tur` follows bit 21 and has no mask.
- R10: `irq` is the OR of `irq_bce` and `irq_tur`.
- R11: While `port_en`=0, both sticky bits and the discard state return to 0 at the next clock edge.
- R12: While `rst_n`=0, both sticky bits and the discard state are 0 after the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_en | input | 1 | Port enable; low clears all sticky state |
| frm_slave | input | 1 | Port takes the frame signal from outside |
| rx_no_tx | input | 1 | Receive-only mode, transmitter idle |
| bce_ie | input | 1 | Bit-count-error interrupt enable |
| bce_evt | input | 1 | Pulse: frame sync seen at a wrong time |
| tx_pop_empty | input | 1 | Pulse: transmitter popped an empty FIFO |
| rx_level | input | 4 | Receive FIFO level |
| tx_level | input | 4 | Transmit FIFO level |
| busy | input | 1 | Port busy |
| css_busy | input | 1 | Slave control-signal synchronisation in progress |
| rx_ne | input | 1 | Receive FIFO not empty |
| tx_nf | input | 1 | Transmit FIFO not full |
| wr_en | input | 1 | CPU write strobe |
| wr_data | input | 32 | CPU write data (ones clear sticky bits) |
| rd_data | output | 32 | Status word |
| rx_sample_vld | input | 1 | A received sample is complete |
| rx_sample_keep | output | 1 | That sample is to be stored |
| irq_bce | output | 1 | Bit-count-error interrupt request |
| irq_tur | output | 1 | Underrun interrupt request |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that `bce_evt` and `tx_pop_empty` are synchronous to `clk` and carry meaning only in the cycle in which they are high. They also assume that the control inputs change only between clock edges. The stimulus drives every input on the falling edge, holds pulses for exactly one cycle, and changes mode bits such as `frm_slave` and `rx_no_tx` only in cycles with no pending event. The stimulus also covers the corner cases: a set and a clear in the same cycle, a pulse that lands on a valid sample, and a pulse that lands between samples.

// File: rtl/sspstat_pkg.sv
// Package: bit positions of the serial-port status word.
// Assumes a 32-bit CPU word; the sticky positions are fixed because
// interrupt and software decode depend on them.
package sspstat_pkg;
    localparam int WORD_W    = 32;
    localparam int POS_BCE   = 23;
    localparam int POS_CSS   = 22;
    localparam int POS_TUR   = 21;
    localparam int POS_TXNF  = 2;
    localparam int POS_RXNE  = 3;
    localparam int POS_BUSY  = 4;
    localparam int POS_TXLVL = 8;
    localparam int NUM_STK   = 2;

    // Sticky index to bit position: 0 = bit-count error, 1 = underrun
    function automatic int stk_pos(input int idx);
        return (idx == 0) ? POS_BCE : POS_TUR;
    endfunction
endpackage

// File: rtl/sspstat_sticky.sv
// Module: one sticky write-one-to-clear status bit.
// A set in the same cycle as a clear wins. A low enable forces the bit to 0.
// Assumes set and clr are single-cycle synchronous strobes.
module sspstat_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Holds the bit: reset/disable clear, set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            q <= 1'b0;
        end else if (set) begin
            q <= 1'b1;
        end else if (clr) begin
            q <= 1'b0;
        end
    end
endmodule

// File: rtl/sspstat_resync.sv
// Module: receive-sample discard after a frame misalignment.
// Drops DISCARD_N valid samples, counting a sample valid in the same cycle
// as the error. Assumes err is already qualified by the port enable.
module sspstat_resync #(
    parameter int DISCARD_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic err,
    input  logic vld,
    output logic keep
);
    localparam int CNT_W = $clog2(DISCARD_N + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(DISCARD_N);

    logic [CNT_W-1:0] pend;
    logic [CNT_W-1:0] pend_eff;

    // Effective pending count including an error arriving this cycle
    always_comb begin
        pend_eff = err ? LOAD : pend;
        keep     = vld && (pend_eff == '0);
    end

    // Counts down the samples still to be discarded
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            pend <= '0;
        end else if (err) begin
            pend <= vld ? LOAD - CNT_W'(1) : LOAD;
        end else if (vld && pend != '0) begin
            pend <= pend - CNT_W'(1);
        end
    end
endmodule

// File: rtl/sspstat_rdmux.sv
// Module: assembles the status word from sticky bits and live flags.
// Unassigned positions read as zero. Assumes TXLVL + 2*LVL_W <= 21.
module sspstat_rdmux
    import sspstat_pkg::*;
#(
    parameter int LVL_W = 4
) (
    input  logic [NUM_STK-1:0] stk_q,
    input  logic               css_vis,
    input  logic [LVL_W-1:0]   rx_level,
    input  logic [LVL_W-1:0]   tx_level,
    input  logic               busy,
    input  logic               rx_ne,
    input  logic               tx_nf,
    output logic [WORD_W-1:0]  word
);
    localparam int POS_RXLVL = POS_TXLVL + LVL_W;

    // Places every field at its position, all else zero
    always_comb begin
        word = '0;
        for (int i = 0; i < NUM_STK; i++) begin
            word[stk_pos(i)] = stk_q[i];
        end
        word[POS_CSS]                = css_vis;
        word[POS_TXLVL +: LVL_W]     = tx_level;
        word[POS_RXLVL +: LVL_W]     = rx_level;
        word[POS_BUSY]               = busy;
        word[POS_RXNE]               = rx_ne;
        word[POS_TXNF]               = tx_nf;
    end
endmodule

// File: rtl/sspstat_reg.sv
// Module: status and interrupt register of a synchronous serial port.
// Holds bit-count-error and underrun faults as sticky bits, passes flags
// through, drives the interrupt requests and the sample-discard helper.
// Assumes all inputs are synchronous to clk; event inputs are 1-cycle pulses.
module sspstat_reg
    import sspstat_pkg::*;
#(
    parameter int LVL_W     = 4,
    parameter int DISCARD_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_en,
    input  logic              frm_slave,
    input  logic              rx_no_tx,
    input  logic              bce_ie,
    input  logic              bce_evt,
    input  logic              tx_pop_empty,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic              busy,
    input  logic              css_busy,
    input  logic              rx_ne,
    input  logic              tx_nf,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    input  logic              rx_sample_vld,
    output logic              rx_sample_keep,
    output logic              irq_bce,
    output logic              irq_tur,
    output logic              irq
);
    logic [NUM_STK-1:0] stk_set;
    logic [NUM_STK-1:0] stk_clr;
    logic [NUM_STK-1:0] stk_q;
    logic               bce_qual;

    // Qualifies the hardware set events for each sticky bit
    always_comb begin
        bce_qual   = bce_evt && port_en;
        stk_set[0] = bce_qual;
        stk_set[1] = tx_pop_empty && frm_slave && !rx_no_tx;
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_STK; gi++) begin : g_stk
            assign stk_clr[gi] = wr_en && wr_data[stk_pos(gi)];
            sspstat_sticky u_bit (
                .clk    (clk),
                .rst_n  (rst_n),
                .enable (port_en),
                .set    (stk_set[gi]),
                .clr    (stk_clr[gi]),
                .q      (stk_q[gi])
            );
        end
    endgenerate

    sspstat_resync #(.DISCARD_N(DISCARD_N)) u_resync (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (port_en),
        .err    (bce_qual),
        .vld    (rx_sample_vld),
        .keep   (rx_sample_keep)
    );

    sspstat_rdmux #(.LVL_W(LVL_W)) u_rdmux (
        .stk_q    (stk_q),
        .css_vis  (css_busy && frm_slave),
        .rx_level (rx_level),
        .tx_level (tx_level),
        .busy     (busy),
        .rx_ne    (rx_ne),
        .tx_nf    (tx_nf),
        .word     (rd_data)
    );

    // Interrupt requests: the bit-count error is maskable, the underrun is not
    always_comb begin
        irq_bce = stk_q[0] && bce_ie;
        irq_tur = stk_q[1];
        irq     = irq_bce || irq_tur;
    end
endmodule

// File: rtl/sspstat_reg_chk.sv
// Checker: temporal properties of the status register, bound to the top.
// Assumes event inputs are synchronous single-cycle pulses.
module sspstat_reg_chk
    import sspstat_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              port_en,
    input logic              frm_slave,
    input logic              rx_no_tx,
    input logic              bce_evt,
    input logic              tx_pop_empty,
    input logic              wr_en,
    input logic [WORD_W-1:0] wr_data,
    input logic [WORD_W-1:0] rd_data,
    input logic              rx_sample_keep,
    input logic              irq_bce,
    input logic              irq_tur,
    input logic              irq
);
    // R1: an enabled error pulse sets bit 23
    p_bce_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        port_en && bce_evt |=> rd_data[POS_BCE]);

    // R1: without a clearing write the bit holds
    p_bce_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        port_en && rd_data[POS_BCE] && !(wr_en && wr_data[POS_BCE]) |=> rd_data[POS_BCE]);

    // R2: set and clear together leave the bit set
    p_set_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        port_en && bce_evt && wr_en && wr_data[POS_BCE] |=> rd_data[POS_BCE]);

    // R4: the sample coinciding with an error is never kept
    p_drop_now_r4: assert property (@(posedge clk) disable iff (!rst_n)
        port_en && bce_evt |-> !rx_sample_keep);

    // R5: underrun never rises without a qualified pop
    p_tur_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[POS_TUR] && !(tx_pop_empty && frm_slave && !rx_no_tx) |=> !rd_data[POS_TUR]);

    // R9: underrun request mirrors its status bit
    p_tur_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tur == rd_data[POS_TUR]);

    // R10: combined request is the OR of the sources
    p_irq_or_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (irq_bce || irq_tur));

    // R11: disabling clears both sticky bits
    p_dis_clr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> !rd_data[POS_BCE] && !rd_data[POS_TUR]);
endmodule

bind sspstat_reg sspstat_reg_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .port_en        (port_en),
    .frm_slave      (frm_slave),
    .rx_no_tx       (rx_no_tx),
    .bce_evt        (bce_evt),
    .tx_pop_empty   (tx_pop_empty),
    .wr_en          (wr_en),
    .wr_data        (wr_data),
    .rd_data        (rd_data),
    .rx_sample_keep (rx_sample_keep),
    .irq_bce        (irq_bce),
    .irq_tur        (irq_tur),
    .irq            (irq)
);

// File: tb/sspstat_reg_bench.sv
// Bench: behavioural reference model compared against the design every cycle.
module sspstat_reg_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        port_en = 1'b0, frm_slave = 1'b0, rx_no_tx = 1'b0, bce_ie = 1'b0;
    logic        bce_evt = 1'b0, tx_pop_empty = 1'b0;
    logic [3:0]  rx_level = 4'h0, tx_level = 4'h0;
    logic        busy = 1'b0, css_busy = 1'b0, rx_ne = 1'b0, tx_nf = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = 32'h0;
    logic [31:0] rd_data;
    logic        rx_sample_vld = 1'b0;
    logic        rx_sample_keep, irq_bce, irq_tur, irq;

    int    vectors = 0, miscompares = 0;
    string tag = "R12";
    bit    m_bce = 0, m_tur = 0;
    int    m_disc = 0;

    always #10 clk = ~clk;

    sspstat_reg u_sspstat_reg (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .frm_slave(frm_slave),
        .rx_no_tx(rx_no_tx), .bce_ie(bce_ie), .bce_evt(bce_evt),
        .tx_pop_empty(tx_pop_empty), .rx_level(rx_level), .tx_level(tx_level),
        .busy(busy), .css_busy(css_busy), .rx_ne(rx_ne), .tx_nf(tx_nf),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .rx_sample_vld(rx_sample_vld), .rx_sample_keep(rx_sample_keep),
        .irq_bce(irq_bce), .irq_tur(irq_tur), .irq(irq)
    );

    // Reference model state update on each rising edge
    always @(posedge clk) begin
        if (!rst_n || !port_en) begin
            m_bce = 0; m_tur = 0; m_disc = 0;
        end else begin
            if (wr_en && wr_data[23]) m_bce = 0;
            if (bce_evt) m_bce = 1;
            if (wr_en && wr_data[21]) m_tur = 0;
            if (tx_pop_empty && frm_slave && !rx_no_tx) m_tur = 1;
            if (bce_evt) m_disc = rx_sample_vld ? 1 : 2;
            else if (rx_sample_vld && m_disc > 0) m_disc = m_disc - 1;
        end
    end

    task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s (phase %s) t=%0t actual=%h expected=%h", req, tag, $time, act, exp);
        end
    endtask

    // Compares every output with the model while inputs are stable
    task automatic compare_all();
        logic e_keep, e_ibce;
        cmp("R1", {31'b0, rd_data[23]}, {31'b0, m_bce});
        cmp("R5", {31'b0, rd_data[21]}, {31'b0, m_tur});
        cmp("R6", {31'b0, rd_data[22]}, {31'b0, css_busy && frm_slave});
        cmp("R7", {16'b0, rd_data[15:8], 3'b0, rd_data[4:2], 2'b0},
                  {16'b0, rx_level, tx_level, 3'b0, busy, rx_ne, tx_nf, 2'b0});
        cmp("R8", rd_data & 32'hFF1F_00E3, 32'h0);
        e_ibce = m_bce && bce_ie;
        cmp("R3", {31'b0, irq_bce}, {31'b0, e_ibce});
        cmp("R9", {31'b0, irq_tur}, {31'b0, m_tur});
        cmp("R10", {31'b0, irq}, {31'b0, e_ibce || m_tur});
        e_keep = rx_sample_vld && !(bce_evt && port_en) && (m_disc == 0);
        cmp("R4", {31'b0, rx_sample_keep}, {31'b0, e_keep});
    endtask

    // One cycle: check mid-low phase, clock, drop pulses on falling edge
    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            #5;
            compare_all();
            @(posedge clk);
            @(negedge clk);
            bce_evt = 0; tx_pop_empty = 0; wr_en = 0; wr_data = 0; rx_sample_vld = 0;
        end
    endtask

    task automatic cpu_wr(input logic [31:0] d);
        wr_en = 1; wr_data = d;
    endtask

    initial begin
        #100000;
        miscompares++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        @(negedge clk);
        tag = "R12";
        rx_level = 4'h5; tx_level = 4'hA; busy = 1; rx_ne = 1;
        bce_evt = 1; port_en = 1; frm_slave = 1; tx_pop_empty = 1;
        tick(1);
        tick(2);
        rst_n = 1;
        tag = "R7"; port_en = 1; frm_slave = 0;
        tx_nf = 1; rx_level = 4'hF; tx_level = 4'h3;
        cpu_wr(32'hFFFF_FFFF); tick(1);
        busy = 0; rx_ne = 0; rx_level = 4'h0; tick(1);
        tag = "R8"; cpu_wr(32'hFF1F_00E3); tick(1);

        tag = "R1"; bce_ie = 0; bce_evt = 1; tick(1);
        tick(2);
        cpu_wr(32'hFF7F_FFFF); tick(1);
        tag = "R3"; bce_ie = 1; tick(2);
        tag = "R1"; cpu_wr(32'h0080_0000); tick(2);
        tag = "R2"; bce_evt = 1; cpu_wr(32'h0080_0000); tick(1);
        tick(1);
        cpu_wr(32'h0080_0000); tick(1);

        tag = "R5"; frm_slave = 0; tx_pop_empty = 1; tick(2);
        frm_slave = 1; rx_no_tx = 1; tx_pop_empty = 1; tick(2);
        rx_no_tx = 0; tx_pop_empty = 1; tick(1);
        tag = "R9"; bce_ie = 0; tick(1);
        tag = "R10"; bce_evt = 1; bce_ie = 1; tick(2);
        tag = "R2"; tx_pop_empty = 1; cpu_wr(32'h00A0_0000); tick(1);
        tick(1);
        tag = "R5"; cpu_wr(32'h0020_0000); tick(2);

        tag = "R4";
        for (int k = 0; k < 4; k++) begin rx_sample_vld = 1; tick(1); end
        rx_sample_vld = 1; bce_evt = 1; tick(1);
        tick(1);
        for (int k = 0; k < 3; k++) begin rx_sample_vld = 1; tick(1); end
        bce_evt = 1; tick(1);
        for (int k = 0; k < 4; k++) begin rx_sample_vld = 1; tick(1); tick(1); end
        bce_evt = 1; tick(1);
        rx_sample_vld = 1; bce_evt = 1; tick(1);
        for (int k = 0; k < 3; k++) begin rx_sample_vld = 1; tick(1); end

        tag = "R11"; bce_evt = 1; tx_pop_empty = 1; tick(1);
        bce_evt = 1; tick(1);
        port_en = 0; rx_sample_vld = 1; tick(1);
        bce_evt = 1; tx_pop_empty = 1; rx_sample_vld = 1; tick(1);
        tx_pop_empty = 1; tick(2);
        port_en = 1; rx_sample_vld = 1; tick(2);

        tag = "R6"; css_busy = 1; frm_slave = 0; tick(1);
        frm_slave = 1; cpu_wr(32'h0040_0000); tick(1);
        css_busy = 0; tick(1);

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule